// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small microcontroller core and decides which of six interrupt sources the core services next. The sources are two external inputs, three timers and one serial port. The first four sources raise a pulse that sets a flag held inside the block. The serial and second-timer sources each present two level flags that software owns, and the block ORs each pair together. The core writes an 8-bit enable register and an 8-bit priority register.

Once per machine-cycle strobe the block picks the winning pending source. It offers the core a request line and a 16-bit vector address. It records which priority level is in service when the core acknowledges.

A low-level routine may be preempted by a high-level request, but a high-level routine never is. A return-from-interrupt strobe releases the innermost active level. Any write to the control registers also blocks acceptance for one instruction, and so does the return.

Top module: `vic2_ctrl`

## Requirements
- R1: After reset, the enable register, priority register, in-service bits, internal flags and request are all zero.
- R2: A source can request only when its own enable bit and enable bit 7 (global) are both 1; bit 6 has no effect. Enable bits: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R3: `flag_stat` shows every source flag in the R2 bit order, even when disabled. Bit 4 is `ser_rx | ser_tx` and bit 5 is `t2_a | t2_b`. Bits 0..3 are set by a pulse on `src_set[0..3]`.
- R4: The vector is 0003h + 8 × source index, giving 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh.
- R5: Among pending sources of one level, the lowest bit index wins.
- R6: A priority bit of 1 makes that source high level. A high request is offered only when no high routine is in service. A low request is offered only when nothing is in service, so a high request preempts a low routine.
- R7: An acknowledge while a request is offered sets the in-service bit of that request's level (`insvc[1]` high, `insvc[0]` low) and drops the request. It clears the flag of the acknowledged source only for bits 0..3; a set pulse in the same cycle wins over that clear.
- R8: A return clears `insvc[1]` if it is set, and otherwise clears `insvc[0]`.
- R9: In a cycle with a return or a register write, the request drops. The first strobe after that event performs no evaluation.
- R10: Request and vector are re-evaluated only at an unblocked strobe, and stay unchanged between strobes unless acknowledged or blocked.
- R11: An acknowledge with no request offered changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | Machine-cycle strobe: evaluation point |
| src_set | input | 4 | Set pulses for external 0, timer 0, external 1, timer 1 flags |
| ser_rx | input | 1 | Serial receive flag (software cleared) |
| ser_tx | input | 1 | Serial transmit flag (software cleared) |
| t2_a | input | 1 | Timer 2 first flag (software cleared) |
| t2_b | input | 1 | Timer 2 second flag (software cleared) |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| pri_wr | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 8 | Priority register write data |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_ack | input | 1 | Core has taken the vector |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the offered request |
| flag_stat | output | 6 | Source flag status |
| en_rd | output | 8 | Enable register contents |
| pri_rd | output | 8 | Priority register contents |
| insvc | output | 2 | In-service bits, bit 1 high level, bit 0 low level |

## Verification
The hardest state to reach from the ports is a nested one. A low routine must already be in service, a high request must be offered on top of it, and a return must then fall back to the low level with the high request becoming eligible again only after the blocked strobe. A directed sequence builds this state step by step: enable a low source, acknowledge it, then raise the serial source's priority while its flag stays set, acknowledge, return, and strobe twice. Long random runs then mix strobes, acknowledges, returns and register writes. Every cycle is compared against a bench-side model of the requirements.

// File: rtl/vic2_pkg.sv
package vic2_pkg;
    localparam int NSRC     = 6;
    localparam int NAUTO    = 4;
    localparam int RW       = 8;
    localparam int AW       = 16;
    localparam int GEN_BIT  = 7;
    localparam int IDXW     = $clog2(NSRC);
    localparam logic [AW-1:0] VEC_BASE = 16'h0003;
    localparam int VEC_STEP = 8;

    typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

    typedef struct packed {
        logic            vld;
        lvl_e            lvl;
        logic [IDXW-1:0] idx;
    } pick_t;

    // lowest set index of a source vector
    function automatic logic [IDXW-1:0] first_set(input logic [NSRC-1:0] v);
        logic [IDXW-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDXW'(i);
        end
        return r;
    endfunction

    function automatic logic [AW-1:0] vec_addr(input logic [IDXW-1:0] idx);
        return VEC_BASE + AW'(idx) * AW'(VEC_STEP);
    endfunction
endpackage

// File: rtl/vic2_flags.sv
module vic2_flags
    import vic2_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NAUTO-1:0] set_auto,
    input  logic [NAUTO-1:0] clr_auto,
    input  logic             ser_rx,
    input  logic             ser_tx,
    input  logic             t2_a,
    input  logic             t2_b,
    output logic [NSRC-1:0]  flags
);
    logic [NAUTO-1:0] auto_q;

    for (genvar g = 0; g < NAUTO; g++) begin : g_auto
        always_ff @(posedge clk) begin
            if (rst)              auto_q[g] <= 1'b0;
            else if (set_auto[g]) auto_q[g] <= 1'b1;
            else if (clr_auto[g]) auto_q[g] <= 1'b0;
        end
    end

    assign flags = {t2_a | t2_b, ser_rx | ser_tx, auto_q};
endmodule

// File: rtl/vic2_pick.sv
module vic2_pick
    import vic2_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] prio,
    input  logic [1:0]      insvc,
    output pick_t           pk
);
    logic [NSRC-1:0] hi, lo;

    always_comb begin
        hi = pend & prio;
        lo = pend & ~prio;
        pk = '0;
        if (|hi && !insvc[1]) begin
            pk.vld = 1'b1;
            pk.lvl = LVL_HI;
            pk.idx = first_set(hi);
        end else if (|lo && insvc == 2'b00) begin
            pk.vld = 1'b1;
            pk.lvl = LVL_LO;
            pk.idx = first_set(lo);
        end
    end
endmodule

// File: rtl/vic2_svc.sv
module vic2_svc
    import vic2_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  lvl_e       take_lvl,
    input  logic       reti,
    output logic [1:0] insvc
);
    logic [1:0] nxt;

    always_comb begin
        nxt = insvc;
        if (reti) begin
            if (nxt[1]) nxt[1] = 1'b0;
            else        nxt[0] = 1'b0;
        end
        if (take) nxt[take_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) insvc <= 2'b00;
        else     insvc <= nxt;
    end

    // R8
    reti_hi_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && insvc[1]) |=> !insvc[1]);

    // R8
    reti_lo_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && insvc == 2'b01 && !take) |=> insvc == 2'b00);

    // R7
    take_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (take && take_lvl == LVL_HI) |=> insvc[1]);
endmodule

// File: rtl/vic2_ctrl.sv
module vic2_ctrl
    import vic2_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_stb,
    input  logic [NAUTO-1:0] src_set,
    input  logic             ser_rx,
    input  logic             ser_tx,
    input  logic             t2_a,
    input  logic             t2_b,
    input  logic             en_wr,
    input  logic [RW-1:0]    en_wdata,
    input  logic             pri_wr,
    input  logic [RW-1:0]    pri_wdata,
    input  logic             reti,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [AW-1:0]    irq_vec,
    output logic [NSRC-1:0]  flag_stat,
    output logic [RW-1:0]    en_rd,
    output logic [RW-1:0]    pri_rd,
    output logic [1:0]       insvc
);
    logic [RW-1:0]    en_q, pri_q;
    logic             hold_q, req_q;
    lvl_e             lvl_q;
    logic [IDXW-1:0]  src_q;
    logic             evt, take, eval;
    logic [NSRC-1:0]  flags, pend;
    logic [NAUTO-1:0] clr_auto;
    pick_t            pk;

    assign evt  = reti | en_wr | pri_wr;
    assign take = irq_ack & req_q;
    assign eval = cyc_stb & ~evt & ~hold_q;
    assign pend = flags & en_q[NSRC-1:0] & {NSRC{en_q[GEN_BIT]}};

    for (genvar g = 0; g < NAUTO; g++) begin : g_clr
        assign clr_auto[g] = take && (src_q == IDXW'(g));
    end

    vic2_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_auto (src_set),
        .clr_auto (clr_auto),
        .ser_rx   (ser_rx),
        .ser_tx   (ser_tx),
        .t2_a     (t2_a),
        .t2_b     (t2_b),
        .flags    (flags)
    );

    vic2_pick u_pick (
        .pend  (pend),
        .prio  (pri_q[NSRC-1:0]),
        .insvc (insvc),
        .pk    (pk)
    );

    vic2_svc u_svc (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .take_lvl (lvl_q),
        .reti     (reti),
        .insvc    (insvc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pri_q  <= '0;
            hold_q <= 1'b0;
            req_q  <= 1'b0;
            lvl_q  <= LVL_LO;
            src_q  <= '0;
        end else begin
            if (en_wr)  en_q  <= en_wdata;
            if (pri_wr) pri_q <= pri_wdata;
            if (evt)          hold_q <= 1'b1;
            else if (cyc_stb) hold_q <= 1'b0;
            if (evt || take) begin
                req_q <= 1'b0;
            end else if (eval) begin
                req_q <= pk.vld;
                lvl_q <= pk.lvl;
                src_q <= pk.idx;
            end
        end
    end

    assign irq_req   = req_q;
    assign irq_vec   = vec_addr(src_q);
    assign flag_stat = flags;
    assign en_rd     = en_q;
    assign pri_rd    = pri_q;

    // R9
    blk_drop_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> !irq_req);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !cyc_stb && !irq_ack && !evt) |=> (irq_req && $stable(irq_vec)));

    // R6
    hi_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && lvl_q == LVL_HI) |-> !insvc[1]);

    // R6
    lo_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && lvl_q == LVL_LO) |-> insvc == 2'b00);

    // R4
    vec_align_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_vec[2:0] == 3'b011);
endmodule

// File: tb/sim_vic2_ctrl.sv
`timescale 1ns/1ps
module sim_vic2_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_stb = 1'b0;
    logic [3:0] src_set = '0;
    logic ser_rx = 1'b0, ser_tx = 1'b0, t2_a = 1'b0, t2_b = 1'b0;
    logic en_wr = 1'b0, pri_wr = 1'b0, reti = 1'b0, irq_ack = 1'b0;
    logic [7:0] en_wdata = '0, pri_wdata = '0;
    logic irq_req;
    logic [15:0] irq_vec;
    logic [5:0] flag_stat;
    logic [7:0] en_rd, pri_rd;
    logic [1:0] insvc;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    // bench-side model state
    logic [3:0] m_auto = '0;
    logic [7:0] m_en = '0, m_pri = '0;
    logic [1:0] m_ins = '0;
    logic m_req = 1'b0, m_lvl = 1'b0, m_hold = 1'b0;
    logic [2:0] m_src = '0;

    always #4 clk = ~clk;

    vic2_ctrl u0 (
        .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .src_set(src_set),
        .ser_rx(ser_rx), .ser_tx(ser_tx), .t2_a(t2_a), .t2_b(t2_b),
        .en_wr(en_wr), .en_wdata(en_wdata), .pri_wr(pri_wr), .pri_wdata(pri_wdata),
        .reti(reti), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
        .flag_stat(flag_stat), .en_rd(en_rd), .pri_rd(pri_rd), .insvc(insvc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // winner per R2, R5, R6: {vld, lvl, idx}
    function automatic logic [4:0] mpick(input logic [5:0] fl, input logic [7:0] en,
                                         input logic [7:0] pr, input logic [1:0] ins);
        logic [5:0] pend;
        pend = fl & en[5:0] & {6{en[7]}};
        if (!ins[1])
            for (int i = 0; i < 6; i++) if (pend[i] && pr[i]) return {1'b1, 1'b1, 3'(i)};
        if (ins == 2'b00)
            for (int i = 0; i < 6; i++) if (pend[i] && !pr[i]) return {1'b1, 1'b0, 3'(i)};
        return 5'b0;
    endfunction

    task automatic tick();
        logic [5:0] fl;
        logic [4:0] pk;
        logic take, evt, ev;
        logic [3:0] n_auto;
        logic [1:0] n_ins;
        fl   = {t2_a | t2_b, ser_rx | ser_tx, m_auto};
        take = irq_ack && m_req;
        evt  = reti || en_wr || pri_wr;
        ev   = cyc_stb && !evt && !m_hold;
        pk   = mpick(fl, m_en, m_pri, m_ins);
        n_auto = m_auto;
        if (take && m_src < 3'd4) n_auto[m_src[1:0]] = 1'b0;
        n_auto = n_auto | src_set;
        n_ins = m_ins;
        if (reti) begin
            if (n_ins[1]) n_ins[1] = 1'b0; else n_ins[0] = 1'b0;
        end
        if (take) n_ins[m_lvl] = 1'b1;
        @(posedge clk);
        if (rst) begin
            m_auto = '0; m_en = '0; m_pri = '0; m_ins = '0;
            m_req = 1'b0; m_lvl = 1'b0; m_hold = 1'b0; m_src = '0;
        end else begin
            m_auto = n_auto;
            m_ins  = n_ins;
            if (en_wr)  m_en  = en_wdata;
            if (pri_wr) m_pri = pri_wdata;
            if (evt) m_hold = 1'b1; else if (cyc_stb) m_hold = 1'b0;
            if (evt || take) m_req = 1'b0;
            else if (ev) begin m_req = pk[4]; m_lvl = pk[3]; m_src = pk[2:0]; end
        end
        @(negedge clk);
        chk("R10 request", irq_req, m_req);
        if (m_req) chk("R4 vector", irq_vec, 16'h0003 + 16'(m_src) * 16'd8);
        chk("R3 flags", flag_stat, {t2_a | t2_b, ser_rx | ser_tx, m_auto});
        chk("R7 R8 in-service", insvc, m_ins);
        chk("R2 enable reg", en_rd, m_en);
        chk("R6 priority reg", pri_rd, m_pri);
        src_set = '0; en_wr = 1'b0; pri_wr = 1'b0; reti = 1'b0;
        irq_ack = 1'b0; cyc_stb = 1'b0;
    endtask

    task automatic strobe();
        cyc_stb = 1'b1; tick();
    endtask

    task automatic wr_en(input logic [7:0] d);
        en_wdata = d; en_wr = 1'b1; tick();
        strobe();
    endtask

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 req", irq_req, 0); chk("R1 insvc", insvc, 0);
        chk("R1 en", en_rd, 0); chk("R1 pri", pri_rd, 0); chk("R1 flags", flag_stat, 0);

        // R2 global enable missing, then bit 6 alone
        en_wdata = 8'h7F; en_wr = 1'b1; tick();
        src_set = 4'b0001; tick();
        strobe(); strobe();
        chk("R2 no global", irq_req, 0);
        chk("R3 disabled flag visible", flag_stat, 6'h01);
        wr_en(8'hC0); strobe();
        chk("R2 bit6 ignored", irq_req, 0);
        en_wdata = 8'h81; en_wr = 1'b1; tick();
        strobe();
        chk("R9 blocked strobe", irq_req, 0);
        strobe();
        chk("R2 enabled", irq_req, 1); chk("R4 ext0 vector", irq_vec, 16'h0003);

        // R5 same-level order
        src_set = 4'b1110; ser_rx = 1'b1; tick();
        wr_en(8'hBF); strobe();
        chk("R5 lowest index", irq_vec, 16'h0003);
        irq_ack = 1'b1; tick();
        chk("R7 low mark", insvc, 2'b01);
        chk("R7 auto clear", flag_stat, 6'h1E);
        strobe();
        chk("R6 low blocks low", irq_req, 0);

        // R6 preemption by high serial
        pri_wdata = 8'h10; pri_wr = 1'b1; tick();
        strobe(); strobe();
        chk("R6 preempt", irq_req, 1); chk("R4 serial vector", irq_vec, 16'h0023);
        irq_ack = 1'b1; tick();
        chk("R7 high mark", insvc, 2'b11);
        chk("R7 serial kept", flag_stat, 6'h1E);
        strobe();
        chk("R6 high not preempted", irq_req, 0);
        reti = 1'b1; tick();
        chk("R8 high first", insvc, 2'b01);
        strobe();
        chk("R9 after return", irq_req, 0);
        strobe();
        chk("R6 high again", irq_vec, 16'h0023); chk("R6 high again req", irq_req, 1);
        irq_ack = 1'b1; tick();
        ser_rx = 1'b0;
        reti = 1'b1; tick();
        reti = 1'b1; tick();
        chk("R8 low last", insvc, 2'b00);

        // R11 stray acknowledge
        irq_ack = 1'b1; tick();
        chk("R11 insvc", insvc, 2'b00); chk("R11 flags", flag_stat, 6'h0E);

        // R10 hold between strobes
        strobe(); strobe();
        chk("R10 timer0 vec", irq_vec, 16'h000B);
        src_set = 4'b0001; tick(); tick();
        chk("R10 held", irq_vec, 16'h000B);
        strobe();
        chk("R5 ext0 wins", irq_vec, 16'h0003);

        // random phase
        void'($urandom(32'd2718));
        for (int c = 0; c < 6000; c++) begin
            src_set = ($urandom % 8 == 0) ? 4'($urandom) : 4'b0;
            if ($urandom % 16 == 0) ser_rx = ~ser_rx;
            if ($urandom % 16 == 0) ser_tx = ~ser_tx;
            if ($urandom % 20 == 0) t2_a = ~t2_a;
            if ($urandom % 20 == 0) t2_b = ~t2_b;
            cyc_stb = ($urandom % 3 == 0);
            if ($urandom % 40 == 0) begin
                en_wr = 1'b1;
                en_wdata = 8'($urandom) | (($urandom % 4 != 0) ? 8'h80 : 8'h00);
            end
            if ($urandom % 40 == 0) begin pri_wr = 1'b1; pri_wdata = 8'($urandom); end
            irq_ack = m_req ? ($urandom % 2 == 0) : ($urandom % 20 == 0);
            if (m_ins != 2'b00 && $urandom % 12 == 0) reti = 1'b1;
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule